// File: doc/BRIEF.md
# Clock-qualified memory address decoder

This block is the glue logic between an 8-bit processor and its memory on a 16-bit address bus with an 8-bit data bus. It decodes the address into active-low chip enables for a RAM region at the bottom of the map and a ROM region at the top. It also turns the processor's read/not-write line into separate active-low write and read strobes. Both strobes are gated by the phase-2 bus clock, so no memory access can start while the address lines are still settling.

The RAM enable is taken straight from the top address bit and is not gated by the clock. The ROM enable is the NAND of the two top address bits. The window between the regions selects nothing. A small synthesizable RAM array and a computed ROM array respond only to these strobes, and a data mux presents the selected byte on `rdata_o`.

The RAM array holds 2^RAM_AW bytes and aliases across its region. The ROM holds 2^ROM_AW bytes and aliases across its region. The RAM samples the qualified write while phase 2 is high. It commits the write at the falling edge of phase 2, which is detected on the system clock `clk_i`.

Top module: `mem_glue`

## Requirements
- R1: `ram_ce_no` equals `addr_i[15]`: it is low exactly for $0000–$7FFF, whatever the levels of `phi2_i` and `rnw_i`.
- R2: `rom_ce_no` is low exactly when `addr_i[15:14]` is 2'b11 ($C000–$FFFF). It is never low together with `ram_ce_no`.
- R3: `wr_no` is low only when `phi2_i` is 1 and `rnw_i` is 0 (a write). At every other time it is high.
- R4: `rd_no` is low only when `phi2_i` is 1 and `rnw_i` is 1 (a read). At every other time it is high.
- R5: A write cycle to the RAM region stores `wdata_i` at index `addr_i[RAM_AW-1:0]`. The write is held through a phase-2-high interval and committed when phase 2 falls. A later read cycle at any address with the same index returns the stored byte.
- R6: A write attempt with `rnw_i` = 0 while `phi2_i` stays low leaves the RAM contents unchanged.
- R7: A read cycle in $8000–$BFFF returns $FF on `rdata_o`.
- R8: A read cycle in the ROM region returns `((idx*29) mod 256) XOR ROM_SEED`, where idx = `addr_i[ROM_AW-1:0]` and the default ROM_SEED is $A5. A write cycle to the ROM region leaves `rdata_o` at $FF and does not change the ROM contents.
- R9: `rdata_o` is $FF whenever `rd_no` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than phase 2 |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phi2_i | input | 1 | Phase-2 bus clock |
| rnw_i | input | 1 | Read/not-write: 1 = read, 0 = write |
| addr_i | input | 16 | Address bus |
| wdata_i | input | 8 | Write data from the processor |
| rdata_o | output | 8 | Read data mux output |
| ram_ce_no | output | 1 | RAM chip enable, active low |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| wr_no | output | 1 | Qualified write strobe, active low |
| rd_no | output | 1 | Qualified read strobe, active low |

## Verification
The chip enables, the strobes and the read mux are combinational, so they are due in the same time step as the input change. The bench samples them 1 ns after driving the inputs on a falling edge of `clk_i`, and for read data it samples while phase 2 is still high. A RAM write commits on the first rising edge of `clk_i` after phase 2 falls, because the previous phase-2 level passes through one register. The bench therefore waits two clock periods after phase 2 falls before it starts the read cycle that checks the byte.

// File: rtl/mem_glue_pkg.sv
package mem_glue_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 16;
  localparam logic [DW-1:0] IDLE_BYTE = 8'hFF;

  typedef logic [DW-1:0] byte_t;

  typedef struct packed {
    logic ram_ce_n;
    logic rom_ce_n;
    logic wr_n;
    logic rd_n;
  } sel_t;

  function automatic byte_t rom_byte(int unsigned idx, byte_t seed);
    logic [31:0] prod;
    prod = idx * 32'd29;
    return prod[7:0] ^ seed;
  endfunction
endpackage

// File: rtl/mem_glue_decode.sv
module mem_glue_decode
  import mem_glue_pkg::*;
(
  input  logic       phi2_i,
  input  logic       rnw_i,
  input  logic [1:0] addr_top_i,
  output sel_t       sel_o
);
  always_comb begin
    sel_o.ram_ce_n = addr_top_i[1];                // ungated
    sel_o.rom_ce_n = ~(addr_top_i[1] & addr_top_i[0]);
    sel_o.wr_n     = ~(phi2_i & ~rnw_i);
    sel_o.rd_n     = ~(phi2_i & rnw_i);
  end
endmodule

// File: rtl/mem_glue_ram.sv
module mem_glue_ram
  import mem_glue_pkg::*;
#(
  parameter int unsigned RAM_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic [RAM_AW-1:0] addr_i,
  input  byte_t             wdata_i,
  output byte_t             rdata_o
);
  localparam int unsigned DEPTH = 2 ** RAM_AW;

  byte_t             mem [DEPTH];
  logic              phi2_q;
  logic              pend_q;
  logic [RAM_AW-1:0] pend_addr_q;
  byte_t             pend_data_q;
  logic              phi2_fall;

  assign phi2_fall = phi2_q & ~phi2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi2_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      phi2_q <= phi2_i;
      if (phi2_fall) begin
        pend_q <= 1'b0;
      end else if (phi2_i) begin
        // latest qualified write in this high phase wins
        pend_q <= ~ce_ni & ~we_ni;
        if (!ce_ni && !we_ni) begin
          pend_addr_q <= addr_i;
          pend_data_q <= wdata_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (phi2_fall && pend_q) mem[pend_addr_q] <= pend_data_q;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/mem_glue_rom.sv
module mem_glue_rom
  import mem_glue_pkg::*;
#(
  parameter int unsigned ROM_AW   = 6,
  parameter byte_t       ROM_SEED = 8'hA5
) (
  input  logic [ROM_AW-1:0] addr_i,
  output byte_t             rdata_o
);
  localparam int unsigned DEPTH = 2 ** ROM_AW;

  byte_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = rom_byte(g, ROM_SEED);
  end

  assign rdata_o = rom[addr_i];
endmodule

// File: rtl/mem_glue.sv
module mem_glue
  import mem_glue_pkg::*;
#(
  parameter int unsigned RAM_AW   = 11,
  parameter int unsigned ROM_AW   = 6,
  parameter logic [7:0]  ROM_SEED = 8'hA5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        phi2_i,
  input  logic        rnw_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        ram_ce_no,
  output logic        rom_ce_no,
  output logic        wr_no,
  output logic        rd_no
);
  sel_t  sel;
  byte_t ram_q;
  byte_t rom_q;
  logic  unused_addr;

  assign unused_addr = ^addr_i;

  mem_glue_decode i_decode (
    .phi2_i     (phi2_i),
    .rnw_i      (rnw_i),
    .addr_top_i (addr_i[15:14]),
    .sel_o      (sel)
  );

  mem_glue_ram #(.RAM_AW(RAM_AW)) i_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phi2_i  (phi2_i),
    .ce_ni   (sel.ram_ce_n),
    .we_ni   (sel.wr_n),
    .addr_i  (addr_i[RAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_q)
  );

  mem_glue_rom #(.ROM_AW(ROM_AW), .ROM_SEED(ROM_SEED)) i_rom (
    .addr_i  (addr_i[ROM_AW-1:0]),
    .rdata_o (rom_q)
  );

  always_comb begin
    rdata_o = IDLE_BYTE;
    if (!sel.rd_n) begin
      if (!sel.ram_ce_n)      rdata_o = ram_q;
      else if (!sel.rom_ce_n) rdata_o = rom_q;
    end
  end

  assign ram_ce_no = sel.ram_ce_n;
  assign rom_ce_no = sel.rom_ce_n;
  assign wr_no     = sel.wr_n;
  assign rd_no     = sel.rd_n;
endmodule

// File: rtl/mem_glue_chk.sv
module mem_glue_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        phi2_i,
  input logic        rnw_i,
  input logic [15:0] addr_i,
  input logic [7:0]  rdata_o,
  input logic        ram_ce_no,
  input logic        rom_ce_no,
  input logic        wr_no,
  input logic        rd_no
);
  assert_ram_ce_ungated_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (!ram_ce_no && rom_ce_no));

  assert_ce_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_ce_no && !rom_ce_no));

  assert_wr_needs_phi2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (phi2_i && !rnw_i && rd_no));

  assert_rd_needs_phi2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (phi2_i && rnw_i && wr_no));

  assert_idle_window_ff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b10) |-> (rdata_o == 8'hFF));

  assert_rom_write_no_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_ce_no && !wr_no) |-> (rdata_o == 8'hFF));
endmodule

bind mem_glue mem_glue_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phi2_i    (phi2_i),
  .rnw_i     (rnw_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .ram_ce_no (ram_ce_no),
  .rom_ce_no (rom_ce_no),
  .wr_no     (wr_no),
  .rd_no     (rd_no)
);

// File: tb/test_mem_glue.sv
`timescale 1ns/1ps
module test_mem_glue;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_AW = 11;
  localparam int ROM_AW = 6;
  localparam logic [7:0] SEED = 8'hA5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phi2_i = 1'b0;
  logic        rnw_i = 1'b1;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        ram_ce_no, rom_ce_no, wr_no, rd_no;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [7:0] model [2**RAM_AW];
  bit         valid [2**RAM_AW];

  mem_glue i_mem_glue (
    .clk_i(clk_i), .rst_ni(rst_ni), .phi2_i(phi2_i), .rnw_i(rnw_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ram_ce_no(ram_ce_no), .rom_ce_no(rom_ce_no), .wr_no(wr_no), .rd_no(rd_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [7:0] exp_rom(logic [15:0] a);
    logic [31:0] p;
    p = 32'(a[ROM_AW-1:0]) * 32'd29;
    return p[7:0] ^ SEED;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // one bus cycle: phi2 low 2 clocks, high 2 clocks, sample, then low 2 clocks
  task automatic bus_cycle(logic [15:0] a, logic rnw, logic [7:0] d, output logic [7:0] q);
    @(negedge clk_i);
    addr_i = a; rnw_i = rnw; wdata_i = d; phi2_i = 1'b0;
    wait_neg(2);
    phi2_i = 1'b1;
    wait_neg(2);
    #1 q = rdata_o;
    @(negedge clk_i);
    phi2_i = 1'b0;
    wait_neg(2);
  endtask

  task automatic ram_write(logic [15:0] a, logic [7:0] d);
    logic [7:0] q;
    bus_cycle(a, 1'b0, d, q);
    check("R9 rdata idle on write", {24'd0, q}, 32'hFF);
    model[a[RAM_AW-1:0]] = d;
    valid[a[RAM_AW-1:0]] = 1'b1;
  endtask

  initial begin
    logic [7:0] q;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    #1;
    // reset state: phi2 low, read, address 0
    check("R3 wr_no reset", {31'd0, wr_no}, 32'd1);
    check("R4 rd_no reset", {31'd0, rd_no}, 32'd1);
    check("R9 rdata reset", {24'd0, rdata_o}, 32'hFF);
    rst_ni = 1'b1;
    wait_neg(2);

    // every phi2/rnw combination
    for (int c = 0; c < 4; c++) begin
      @(negedge clk_i);
      phi2_i = c[1]; rnw_i = c[0]; addr_i = 16'h9000;
      #1;
      check("R3 strobe combo", {31'd0, wr_no}, {31'd0, ~(c[1] & ~c[0])});
      check("R4 strobe combo", {31'd0, rd_no}, {31'd0, ~(c[1] & c[0])});
    end

    // boundary addresses, with both phi2 levels
    for (int p = 0; p < 2; p++) begin
      logic [15:0] bnd [4] = '{16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000};
      for (int i = 0; i < 4; i++) begin
        @(negedge clk_i);
        phi2_i = p[0]; rnw_i = 1'b1; addr_i = bnd[i];
        #1;
        check("R1 boundary ram_ce", {31'd0, ram_ce_no}, {31'd0, bnd[i][15]});
        check("R2 boundary rom_ce", {31'd0, rom_ce_no}, {31'd0, ~(bnd[i][15] & bnd[i][14])});
      end
    end

    // random combinational sweep
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      logic ph, rw;
      a = 16'($urandom); ph = 1'($urandom); rw = 1'($urandom);
      @(negedge clk_i);
      addr_i = a; phi2_i = ph; rnw_i = rw;
      #1;
      check("R1 ram_ce", {31'd0, ram_ce_no}, {31'd0, a[15]});
      check("R2 rom_ce", {31'd0, rom_ce_no}, {31'd0, ~(a[15] & a[14])});
      check("R3 wr_no", {31'd0, wr_no}, {31'd0, ~(ph & ~rw)});
      check("R4 rd_no", {31'd0, rd_no}, {31'd0, ~(ph & rw)});
      if (!(ph && rw)) check("R9 rdata idle", {24'd0, rdata_o}, 32'hFF);
      else if (a[15:14] == 2'b10) check("R7 idle window", {24'd0, rdata_o}, 32'hFF);
      else if (a[15:14] == 2'b11) check("R8 rom read", {24'd0, rdata_o}, {24'd0, exp_rom(a)});
    end
    @(negedge clk_i);
    phi2_i = 1'b0;
    wait_neg(2);

    // directed RAM write/read, including aliasing across the region
    ram_write(16'h0000, 8'h3C);
    ram_write(16'h7FFF, 8'hC3);
    bus_cycle(16'h0000, 1'b1, 8'h00, q);
    check("R5 ram read 0000", {24'd0, q}, 32'h3C);
    bus_cycle(16'h7FFF, 1'b1, 8'h00, q);
    check("R5 ram read 7FFF", {24'd0, q}, 32'hC3);
    bus_cycle(16'h0800, 1'b1, 8'h00, q);
    check("R5 ram alias 0800", {24'd0, q}, 32'h3C);

    // random RAM traffic
    for (int i = 0; i < 120; i++) begin
      logic [15:0] a;
      a = {1'b0, 15'($urandom)};
      if (1'($urandom) || !valid[a[RAM_AW-1:0]]) begin
        ram_write(a, 8'($urandom));
      end else begin
        bus_cycle(a, 1'b1, 8'h00, q);
        check("R5 ram random read", {24'd0, q}, {24'd0, model[a[RAM_AW-1:0]]});
      end
    end

    // write attempt with phi2 held low
    ram_write(16'h0123, 8'h55);
    @(negedge clk_i);
    addr_i = 16'h0123; rnw_i = 1'b0; wdata_i = 8'hAA; phi2_i = 1'b0;
    wait_neg(6);
    #1 check("R6 wr_no high while phi2 low", {31'd0, wr_no}, 32'd1);
    rnw_i = 1'b1;
    wait_neg(2);
    bus_cycle(16'h0123, 1'b1, 8'h00, q);
    check("R6 ram unchanged", {24'd0, q}, 32'h55);

    // idle window read
    bus_cycle(16'h8000, 1'b1, 8'h00, q);
    check("R7 read 8000", {24'd0, q}, 32'hFF);
    bus_cycle(16'hBFFF, 1'b1, 8'h00, q);
    check("R7 read BFFF", {24'd0, q}, 32'hFF);
    // idle-window write must not reach RAM alias
    bus_cycle(16'h8123, 1'b0, 8'h99, q);
    bus_cycle(16'h0123, 1'b1, 8'h00, q);
    check("R7 idle write ignored", {24'd0, q}, 32'h55);

    // ROM read, write attempt, read again
    bus_cycle(16'hC005, 1'b1, 8'h00, q);
    check("R8 rom read C005", {24'd0, q}, {24'd0, exp_rom(16'hC005)});
    bus_cycle(16'hFFFF, 1'b1, 8'h00, q);
    check("R8 rom read FFFF", {24'd0, q}, {24'd0, exp_rom(16'hFFFF)});
    bus_cycle(16'hC005, 1'b0, 8'h00, q);
    check("R8 rom write no drive", {24'd0, q}, 32'hFF);
    bus_cycle(16'hC005, 1'b1, 8'h00, q);
    check("R8 rom unchanged", {24'd0, q}, {24'd0, exp_rom(16'hC005)});
    // ROM write must not reach RAM at the same low bits
    bus_cycle(16'hC123, 1'b0, 8'h77, q);
    bus_cycle(16'h0123, 1'b1, 8'h00, q);
    check("R8 rom write not in ram", {24'd0, q}, 32'h55);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule